// File: doc/BRIEF.md
# SPI Serial Byte-Memory Slave

This block is the serial front end of a small byte-wide nonvolatile store, with the storage modelled as a plain RAM. A host selects it with an active-low chip select and sends an opcode. Depending on the opcode, the host then sends a two-byte address and data bytes, or reads data back. Reads and writes run through an address counter that steps after every byte, so a whole region can be streamed under one select. A status byte holds the write-enable latch, two block-protect bits and a protect-enable bit. Writes to the status byte are gated by that bit together with a write-protect pin.

All serial inputs are oversampled by the block clock. Edges of the serial clock are found by comparing each sample with the previous one. Bits are taken in on rising edges and driven out on falling edges, so both idle clock polarities (mode 0 and mode 3) work. An active-low hold input freezes a transfer partway through a byte without ending the selection. The output is presented as a data bit plus a separate drive-enable, and the pad logic makes the tri-state from those two signals.

Top module: `spi_fram_slave`

## Requirements
- R1: While `cs_n` is high, `so_oe` is low and serial clock activity has no effect. Any command that is only partly shifted in when `cs_n` rises is dropped, and the next selection starts again with an opcode.
- R2: Input bits are taken on rising edges of `sck` and output bits change on falling edges, most significant bit first. This works whether `sck` idles low or high at selection.
- R3: Opcodes are 0x06 set write enable, 0x04 clear write enable, 0x05 read status, 0x01 write status, 0x03 read data and 0x02 write data. Read data and write data are followed by a two-byte address, high byte first. The top 3 address bits are ignored.
- R4: The write-enable latch is set by 0x06 and cleared by 0x04. It is also cleared when `cs_n` rises after a write-data or write-status opcode. Write data and write status change nothing while the latch is clear.
- R5: After each data byte, the address counter steps by one, and 0x1FFF steps to 0x0000. This applies to both reads and writes.
- R6: The status byte reads as bit 7 protect-enable, bits 3:2 block-protect, bit 1 write-enable latch, and all other bits 0. It repeats for as long as clocks continue.
- R7: A status write is ignored while protect-enable is 1 and `wp_n` is low.
- R8: The block-protect values decide which data writes are ignored. Value 01 blocks writes to 0x1800–0x1FFF, 10 blocks 0x1000–0x1FFF, and 11 blocks every address. A blocked write still steps the address.
- R9: While `hold_n` is low with `cs_n` low, `so_oe` is low and `sck`/`si` are ignored. Shifting resumes at the same bit once `hold_n` returns high.
- R10: A data byte is stored only when all 8 of its bits have arrived. A byte cut short by `cs_n` rising leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| wp_n | input | 1 | Active-low status write protect |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for `so` |

## Verification
The assertions assume that `sck`, `si`, `cs_n` and `hold_n` are synchronous to `clk`, and that each level of `sck` lasts at least one `clk` cycle. They also assume that `sck` has the same level when hold is entered and when it is released, so that no edge is hidden by the pause. The stimulus changes every pin on the falling edge of `clk` and holds each `sck` level for four cycles. During a hold, the stimulus toggles `sck` and ends the pause at the level it started from. Expected bytes come from a behavioural model of the memory and status in the bench.

// File: rtl/spi_fram_slave.sv
module spi_fram_slave #(
  parameter int ADDR_W = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;

  typedef enum logic [2:0] {PH_OP, PH_AH, PH_AL, PH_DATA, PH_SKIP} phase_t;

  logic [7:0] mem [DEPTH];
  logic sck_q, cs_q;
  logic [2:0] bitcnt;
  logic [6:0] sh;
  logic [7:0] op;
  logic [ADDR_W-9:0] addr_hi;
  logic [ADDR_W-1:0] addr;
  phase_t phase;
  logic wel, wpen;
  logic [1:0] bp;

  wire active  = !cs_n && hold_n;
  wire rise    = active && sck && !sck_q;
  wire fall    = active && !sck && sck_q;
  wire [7:0] rx = {sh, si};
  wire done    = rise && (bitcnt == 3'd7);
  wire [7:0] status = {wpen, 3'b000, bp, wel, 1'b0};
  wire [7:0] rd_byte = (op == OP_RDSR) ? status : mem[addr];
  wire reading = (phase == PH_DATA) && (op == OP_READ || op == OP_RDSR);
  wire sr_open = wel && !(wpen && !wp_n);
  wire locked  = (bp == 2'd3) ||
                 (bp == 2'd2 && addr[ADDR_W-1]) ||
                 (bp == 2'd1 && &addr[ADDR_W-1:ADDR_W-2]);
  wire wr_cmd  = (op == OP_WRIT || op == OP_WRSR);

  always_ff @(posedge clk)
    if (done && phase == PH_DATA && op == OP_WRIT && wel && !locked)
      mem[addr] <= rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      bitcnt  <= '0;
      sh      <= '0;
      op      <= '0;
      addr_hi <= '0;
      addr    <= '0;
      phase   <= PH_OP;
      wel     <= 1'b0;
      wpen    <= 1'b0;
      bp      <= '0;
      so      <= 1'b0;
      so_oe   <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      so_oe <= active && reading;
      if (cs_n) begin
        bitcnt <= '0;
        phase  <= PH_OP;
        if (!cs_q && phase != PH_OP && wr_cmd) wel <= 1'b0;
      end else begin
        if (fall) so <= rd_byte[~bitcnt];
        if (rise) begin
          sh     <= rx[6:0];
          bitcnt <= bitcnt + 3'd1;
        end
        if (done) begin
          case (phase)
            PH_OP: begin
              op <= rx;
              case (rx)
                OP_WREN: begin wel <= 1'b1; phase <= PH_SKIP; end
                OP_WRDI: begin wel <= 1'b0; phase <= PH_SKIP; end
                OP_RDSR, OP_WRSR: phase <= PH_DATA;
                OP_READ, OP_WRIT: phase <= PH_AH;
                default: phase <= PH_SKIP;
              endcase
            end
            PH_AH: begin addr_hi <= rx[ADDR_W-9:0]; phase <= PH_AL; end
            PH_AL: begin addr <= {addr_hi, rx}; phase <= PH_DATA; end
            PH_DATA: begin
              if (op == OP_WRSR) begin
                if (sr_open) begin
                  wpen <= rx[7];
                  bp   <= rx[3:2];
                end
                phase <= PH_SKIP;
              end else if (op == OP_READ || op == OP_WRIT) begin
                addr <= addr + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R1
  idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !so_oe);

  // R9
  hold_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> !so_oe);

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !cs_n) |=> ($stable(bitcnt) && $stable(sh)));

  // R7
  sr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen && !wp_n) |=> ($stable(wpen) && $stable(bp)));

  // R4
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) && phase != PH_OP && wr_cmd) |=> !wel);
endmodule

// File: tb/spi_fram_slave_tb.sv
module spi_fram_slave_tb;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, hold_n = 1, wp_n = 1;
  wire so, so_oe;
  int n_chk = 0, n_fail = 0;
  bit [7:0] ref_mem [8192];
  bit ref_wel = 0, ref_wpen = 0;
  bit [1:0] ref_bp = 0;
  bit mode3 = 0;
  logic cs_prev = 1;

  spi_fram_slave u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1: idle output off, compared on every clock once select has been high two samples
  always @(negedge clk) begin
    if (rst_n && cs_n && cs_prev) check("R1 idle so_oe", {7'd0, so_oe}, 8'd0);
    cs_prev <= cs_n;
  end

  function automatic bit [7:0] status_m();
    return {ref_wpen, 3'b000, ref_bp, ref_wel, 1'b0};
  endfunction

  function automatic bit prot_m(input int a);
    case (ref_bp)
      2'd3: return 1;
      2'd2: return a >= 4096;
      2'd1: return a >= 6144;
      default: return 0;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start();
    sck = mode3; tick(2);
    cs_n = 0; tick(4);
  endtask

  task automatic stop();
    if (!mode3) sck = 0;
    tick(4);
    cs_n = 1; tick(4);
  endtask

  task automatic do_hold();
    hold_n = 0; tick(2);
    for (int k = 0; k < 3; k++) begin
      sck = 0; si = ~si; tick(2);
      sck = 1; tick(2);
    end
    check("R9 so_oe in hold", {7'd0, so_oe}, 8'd0);
    hold_n = 1; tick(2);
  endtask

  task automatic xbits(input bit [7:0] tx, input int nb, input int hold_bit, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nb; i--) begin
      if (i == hold_bit) do_hold();
      sck = 0; si = tx[i]; tick(4);
      rx[i] = so;
      sck = 1; tick(4);
    end
  endtask

  task automatic cmd1(input bit [7:0] opc);
    logic [7:0] r;
    start(); xbits(opc, 8, -1, r); stop();
    if (opc == 8'h06) ref_wel = 1;
    if (opc == 8'h04) ref_wel = 0;
  endtask

  task automatic rdsr(input int n, input string req);
    logic [7:0] r;
    start(); xbits(8'h05, 8, -1, r);
    for (int k = 0; k < n; k++) begin
      xbits(8'h00, 8, -1, r);
      check(req, r, status_m());
    end
    check({req, " oe"}, {7'd0, so_oe}, 8'd1);
    stop();
  endtask

  task automatic wrsr(input bit [7:0] v);
    logic [7:0] r;
    start(); xbits(8'h01, 8, -1, r); xbits(v, 8, -1, r); stop();
    if (ref_wel && !(ref_wpen && !wp_n)) begin
      ref_wpen = v[7]; ref_bp = v[3:2];
    end
    ref_wel = 0;
  endtask

  task automatic write(input int a, input bit [7:0] d [$], input int hold_bit, input int extra);
    logic [7:0] r;
    int p;
    start(); xbits(8'h02, 8, -1, r);
    xbits(8'(a >> 8), 8, -1, r); xbits(8'(a), 8, -1, r);
    p = a & 8191;
    foreach (d[k]) begin
      xbits(d[k], 8, (k == 0) ? hold_bit : -1, r);
      if (ref_wel && !prot_m(p)) ref_mem[p] = d[k];
      p = (p + 1) % 8192;
    end
    if (extra > 0) xbits(8'hFF, extra, -1, r);
    stop();
    ref_wel = 0;
  endtask

  task automatic read(input int a, input int n, input int hold_bit, input string req);
    logic [7:0] r;
    int p;
    start(); xbits(8'h03, 8, -1, r);
    xbits(8'(a >> 8), 8, -1, r); xbits(8'(a), 8, -1, r);
    p = a & 8191;
    for (int k = 0; k < n; k++) begin
      xbits(8'h00, 8, (k == 1) ? hold_bit : -1, r);
      check(req, r, ref_mem[p]);
      p = (p + 1) % 8192;
    end
    check({req, " oe"}, {7'd0, so_oe}, 8'd1);
    stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    tick(3); rst_n = 1; tick(3);
    check("R1 reset so_oe", {7'd0, so_oe}, 8'd0);
    rdsr(1, "R6 reset status");

    // R4: latch set/clear and gating
    cmd1(8'h06); rdsr(2, "R6 R4 wel set");
    cmd1(8'h04); rdsr(1, "R4 wel cleared by 0x04");
    cmd1(8'h06); write(16'h0010, '{8'hAA}, -1, 0);
    rdsr(1, "R4 wel cleared after write");
    write(16'h0010, '{8'h55}, -1, 0);
    read(16'h0010, 1, -1, "R4 write without latch");

    // R2 R5: sequential in mode 0, readback in mode 3
    cmd1(8'h06); write(16'h0100, '{8'h11, 8'h22, 8'h33}, -1, 0);
    mode3 = 1;
    read(16'h0100, 3, -1, "R2 R5 mode3 sequential read");
    mode3 = 0;
    // R3: top address bits ignored
    read(16'hE100, 2, -1, "R3 upper address bits");

    // R5: wrap
    cmd1(8'h06); write(16'h1FFE, '{8'h5A, 8'hA5, 8'hC3}, -1, 0);
    read(16'h1FFF, 2, -1, "R5 wrap read");

    // R10: cut-off byte
    cmd1(8'h06); write(16'h0200, '{8'h77, 8'h3C}, -1, 0);
    cmd1(8'h06); write(16'h0200, '{8'h78}, -1, 5);
    read(16'h0200, 2, -1, "R10 partial byte dropped");

    // R1: abandoned opcode
    start(); xbits(8'h06, 4, -1, r); stop();
    start(); xbits(8'h00, 3, -1, r); stop();
    rdsr(1, "R1 abandoned opcode");

    // R9: hold inside write and read
    cmd1(8'h06); write(16'h0300, '{8'h96, 8'h69}, 3, 0);
    read(16'h0300, 2, 4, "R9 hold resume");

    // R8: block protect
    cmd1(8'h06); write(16'h17FF, '{8'h01, 8'h02}, -1, 0);
    cmd1(8'h06); write(16'h0FFF, '{8'h03, 8'h04}, -1, 0);
    cmd1(8'h06); wrsr(8'h04); rdsr(1, "R6 R8 bp=01 status");
    cmd1(8'h06); write(16'h17FF, '{8'h11, 8'h12}, -1, 0);
    read(16'h17FF, 2, -1, "R8 upper quarter");
    cmd1(8'h06); wrsr(8'h08);
    cmd1(8'h06); write(16'h0FFF, '{8'h13, 8'h14}, -1, 0);
    read(16'h0FFF, 2, -1, "R8 upper half");
    cmd1(8'h06); wrsr(8'h0C);
    cmd1(8'h06); write(16'h0000, '{8'h15}, -1, 0);
    read(16'h0000, 1, -1, "R8 whole array");
    cmd1(8'h06); wrsr(8'h00);

    // R7: status guard
    cmd1(8'h06); wrsr(8'h80); rdsr(1, "R7 protect-enable set");
    wp_n = 0;
    cmd1(8'h06); wrsr(8'h0C); rdsr(1, "R7 status write blocked");
    wp_n = 1;
    cmd1(8'h06); wrsr(8'h00); rdsr(1, "R7 status write allowed");

    tick(10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule